// File: doc/BRIEF.md
# Prefix Nucleus Adder Stage

This block is the widest stage in the middle of a carry skip adder. The stage is built around a parallel prefix tree instead of a ripple chain. It takes one operand slice from each addend and the carry that arrives from the previous stage. It returns the sum slice. It also returns two summary bits that the neighbouring skip logic needs: a group generate, which says the slice makes a carry by itself, and a group propagate, which says the slice passes an incoming carry straight through.

The logic works in layers. First, each bit position forms its own generate (AND) and propagate (XOR) terms. A Kogge-Stone tree then combines these into prefix terms that cover bit 0 up to each position. The tree never sees the incoming carry, so the full-width group generate and group propagate come out of the tree as soon as it settles. After that, one merge cell per bit folds the incoming carry into the prefix terms to give that bit's carry. A final XOR layer forms the sums. Because of this order, the skip logic next to the stage can start working before the sums are ready.

The slice width is a parameter and must be a power of two. The tree has log2 of that width levels. The block is purely combinational.

Top module: `pfx_nucleus_stage`

## Requirements
- R1: `sum_o` equals the low W bits of `opa_i + opb_i + cin_i`, taken as unsigned values.
- R2: `grp_gen_o` is 1 exactly when `opa_i + opb_i` (with no incoming carry) is 2^W or more.
- R3: `grp_prop_o` is 1 exactly when every bit of `opa_i XOR opb_i` is 1, which means `opa_i + opb_i` equals 2^W-1.
- R4: `grp_gen_o OR (grp_prop_o AND cin_i)` equals bit W of `opa_i + opb_i + cin_i`, the carry out of the slice.
- R5: `grp_gen_o` and `grp_prop_o` are never 1 at the same time.
- R6: `grp_gen_o` and `grp_prop_o` do not depend on `cin_i`. For a fixed operand pair, both values of `cin_i` give the same group outputs.
- R7: When `grp_prop_o` is 1 and `cin_i` is 1, `sum_o` is all zeros. The incoming carry ripples out of the top of the slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | First operand slice |
| opb_i | input | W | Second operand slice |
| cin_i | input | 1 | Carry into the lowest bit of the slice |
| sum_o | output | W | Sum slice |
| grp_gen_o | output | 1 | Slice generates a carry on its own |
| grp_prop_o | output | 1 | Slice passes the incoming carry through |

## Verification
The bench builds the stage with W = 8. At that width, every operand pair with both carry values can be applied: 131,072 input combinations. This covers every carry chain the tree can form, including the all-propagate patterns and the all-generate patterns. Each operand pair is applied twice in a row, once with each carry value, so the independence of the group outputs from the carry is checked for every pair.

// File: rtl/pfx_nucleus_pkg.sv
package pfx_nucleus_pkg;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;

    // Black cell: combine a high group with the adjacent lower group.
    function automatic gp_pair_t black_cell(gp_pair_t hi, gp_pair_t lo);
        gp_pair_t r;
        r.gen  = hi.gen | (hi.prop & lo.gen);
        r.prop = hi.prop & lo.prop;
        return r;
    endfunction

    // Gray cell: only the generate term survives (final carry forming).
    function automatic logic gray_cell(gp_pair_t hi, logic lo_gen);
        return hi.gen | (hi.prop & lo_gen);
    endfunction

endpackage

// File: rtl/pfx_bit_prep.sv
module pfx_bit_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] bit_gen_o,
    output logic [W-1:0] bit_prop_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_gen_o[i]  = opa_i[i] & opb_i[i];
        assign bit_prop_o[i] = opa_i[i] ^ opb_i[i];
    end
endmodule

// File: rtl/pfx_ks_tree.sv
module pfx_ks_tree
    import pfx_nucleus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] bit_gen_i,
    input  logic [W-1:0] bit_prop_i,
    output logic [W-1:0] pre_gen_o,   // G[i:0] for every i
    output logic [W-1:0] pre_prop_o   // P[i:0] for every i
);
    localparam int LEVELS = $clog2(W);

    logic [W-1:0] g_cur, p_cur, g_nxt, p_nxt;

    always_comb begin
        g_cur = bit_gen_i;
        p_cur = bit_prop_i;
        g_nxt = bit_gen_i;
        p_nxt = bit_prop_i;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            g_nxt = g_cur;
            p_nxt = p_cur;
            for (int i = (1 << lvl); i < W; i++) begin
                gp_pair_t hi, lo, r;
                hi.gen  = g_cur[i];
                hi.prop = p_cur[i];
                lo.gen  = g_cur[i - (1 << lvl)];
                lo.prop = p_cur[i - (1 << lvl)];
                r       = black_cell(hi, lo);
                g_nxt[i] = r.gen;
                p_nxt[i] = r.prop;
            end
            g_cur = g_nxt;
            p_cur = p_nxt;
        end
        pre_gen_o  = g_cur;
        pre_prop_o = p_cur;
    end
endmodule

// File: rtl/pfx_carry_merge.sv
module pfx_carry_merge
    import pfx_nucleus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] pre_gen_i,
    input  logic [W-1:0] pre_prop_i,
    input  logic [W-1:0] bit_prop_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] carry_in_bit;

    assign carry_in_bit[0] = cin_i;

    for (genvar i = 1; i < W; i++) begin : g_merge
        gp_pair_t grp;
        assign grp.gen  = pre_gen_i[i-1];
        assign grp.prop = pre_prop_i[i-1];
        assign carry_in_bit[i] = gray_cell(grp, cin_i);
    end

    assign sum_o = bit_prop_i ^ carry_in_bit;

    // Bit W-1 of the prefix terms feeds the group outputs, not a carry here.
    logic unused_top;
    assign unused_top = pre_gen_i[W-1] ^ pre_prop_i[W-1];
endmodule

// File: rtl/pfx_nucleus_stage.sv
module pfx_nucleus_stage #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    localparam bit W_IS_POW2 = (W >= 2) && ((W & (W - 1)) == 0);

    if (!W_IS_POW2) begin : g_bad_width
        initial $error("pfx_nucleus_stage: W must be a power of two");
    end

    logic [W-1:0] bit_gen, bit_prop, pre_gen, pre_prop;

    pfx_bit_prep #(.W(W)) u_prep (
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .bit_gen_o  (bit_gen),
        .bit_prop_o (bit_prop)
    );

    pfx_ks_tree #(.W(W)) u_tree (
        .bit_gen_i  (bit_gen),
        .bit_prop_i (bit_prop),
        .pre_gen_o  (pre_gen),
        .pre_prop_o (pre_prop)
    );

    assign grp_gen_o  = pre_gen[W-1];
    assign grp_prop_o = pre_prop[W-1];

    pfx_carry_merge #(.W(W)) u_merge (
        .pre_gen_i  (pre_gen),
        .pre_prop_i (pre_prop),
        .bit_prop_i (bit_prop),
        .cin_i      (cin_i),
        .sum_o      (sum_o)
    );
endmodule

// File: rtl/pfx_nucleus_chk.sv
module pfx_nucleus_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         cin_i,
    input logic [W-1:0] sum_o,
    input logic         grp_gen_o,
    input logic         grp_prop_o
);
    logic [W:0] total_with_c, total_no_c;

    always_comb begin
        total_with_c = {1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, cin_i};
        total_no_c   = {1'b0, opa_i} + {1'b0, opb_i};

        p_sum_exact_r1: assert (sum_o == total_with_c[W-1:0])
            else $error("R1 sum mismatch");
        p_grp_gen_r2: assert (grp_gen_o == total_no_c[W])
            else $error("R2 group generate mismatch");
        p_grp_prop_r3: assert (grp_prop_o == (total_no_c == {1'b0, {W{1'b1}}}))
            else $error("R3 group propagate mismatch");
        p_skip_carry_r4: assert ((grp_gen_o | (grp_prop_o & cin_i)) == total_with_c[W])
            else $error("R4 skip carry mismatch");
        p_gen_prop_excl_r5: assert (!(grp_gen_o && grp_prop_o))
            else $error("R5 generate and propagate both high");
        p_pass_zero_r7: assert (!(grp_prop_o && cin_i) || (sum_o == '0))
            else $error("R7 pass-through sum not zero");
    end
endmodule

bind pfx_nucleus_stage pfx_nucleus_chk #(.W(W)) u_chk (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .cin_i      (cin_i),
    .sum_o      (sum_o),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
);

// File: tb/pfx_nucleus_stage_tb_top.sv
`timescale 1ns/1ps
module pfx_nucleus_stage_tb_top;
    localparam int W = 8;
    localparam int WATCHDOG_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic cin = 1'b0;
    logic [W-1:0] sum;
    logic gg, gp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    pfx_nucleus_stage #(.W(W)) dut_i (
        .opa_i      (opa),
        .opb_i      (opb),
        .cin_i      (cin),
        .sum_o      (sum),
        .grp_gen_o  (gg),
        .grp_prop_o (gp)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     req, opa, opb, cin, act, exp);
        end
    endtask

    // Drive on the falling edge; compare at the next rising edge.
    task automatic apply_and_check(input int a, input int b, input int c,
                                   output int got_gg, output int got_gp);
        int tot, exp_gg, exp_gp;
        @(negedge clk);
        opa = W'(a);
        opb = W'(b);
        cin = c[0];
        @(posedge clk);
        tot    = a + b + c;
        exp_gg = ((a + b) >= (1 << W)) ? 1 : 0;
        exp_gp = ((a ^ b) == ((1 << W) - 1)) ? 1 : 0;
        check("R1", int'(sum), tot % (1 << W));
        check("R2", int'(gg), exp_gg);
        check("R3", int'(gp), exp_gp);
        check("R4", int'(gg | (gp & cin)), tot >> W);
        check("R5", int'(gg & gp), 0);
        if (gp && c == 1) check("R7", int'(sum), 0);
        got_gg = int'(gg);
        got_gp = int'(gp);
    endtask

    initial begin
        int g0, p0, g1, p1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state with all inputs low: zero sum, no group flags.
        @(posedge clk);
        check("R1", int'(sum), 0);
        check("R2", int'(gg), 0);
        check("R3", int'(gp), 0);
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                apply_and_check(a, b, 0, g0, p0);
                apply_and_check(a, b, 1, g1, p1);
                check("R6", g1, g0);  // group generate unaffected by carry
                check("R6", p1, p0);  // group propagate unaffected by carry
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before the sweep completed");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule